// File: doc/BRIEF.md
# FIFO Threshold Transfer Request Generator

This block sits next to one channel's transmit and receive character FIFOs in a serial controller. It decides when the host should service them, whether the host uses interrupts or DMA. It raises a receive request when the receive FIFO should be emptied, and a transmit request when the transmit FIFO has room to be refilled. One 4-bit threshold governs both directions.

In asynchronous mode, a receive timeout or a receive data exception also forces a receive request. In synchronous mode, an end of frame does the same. These causes are latched and stay pending until the host acknowledges them with a read strobe. In synchronous mode, once the last character of a frame has been written into the transmit FIFO, refill requests are held off. The hold-off lasts until the FIFO drains to empty or a new frame is started.

Both requests are combinational functions of registered state. A change in occupancy therefore shows on the requests one clock after it appears at the inputs.

Top module: `xfer_req_gen`

## Requirements
- R1: While reset is asserted both requests are low, and after reset no timeout, exception or end-of-frame cause is pending.
- R2: One clock after the receive count is strictly greater than the effective threshold, the receive request is high. A count equal to the threshold raises nothing.
- R3: A programmed threshold above 12 acts as 12. For example, a setting of 15 with 13 characters received raises the receive request, and with 12 characters it does not.
- R4: One clock after the transmit free space (16 minus the transmit count) is strictly greater than the effective threshold, the transmit request is high, unless R8 suppresses it. A full FIFO never requests.
- R5: In asynchronous mode (syncMode = 0), a one-cycle receive timeout or receive exception pulse raises the receive request from the next clock, whatever the occupancy. The request holds until a clock with hostAck high.
- R6: In synchronous mode (syncMode = 1), a one-cycle end-of-frame pulse raises the receive request in the same way and holds it until acknowledged. Timeout and exception pulses are ignored in this mode.
- R7: In asynchronous mode an end-of-frame pulse is ignored.
- R8: In synchronous mode, a transmit write flagged as the frame's last character forces the transmit request low from the next clock. The suppression clears on a clock where the transmit count is 0 or a frame start is signalled. In asynchronous mode the last-character flag has no effect.
- R9: An occupancy-based request drops one clock after its condition is removed.
- R10: When a cause pulse and hostAck occur in the same clock, the cause wins and stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| thrCfg | input | 4 | Programmed transfer threshold in characters |
| syncMode | input | 1 | 1 = synchronous framing, 0 = asynchronous |
| rxCount | input | 5 | Receive FIFO occupancy, 0 to 16 |
| txCount | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rxTimeout | input | 1 | Receive timeout pulse |
| rxExcept | input | 1 | Receive data exception pulse |
| rxEof | input | 1 | End of received frame pulse |
| txWrite | input | 1 | A character is written into the transmit FIFO |
| txLastChar | input | 1 | Qualifies txWrite: the character ends the frame |
| txFrameStart | input | 1 | A new transmit frame begins |
| hostAck | input | 1 | Host read strobe; clears pending receive causes |
| rxReq | output | 1 | Receive transfer request |
| txReq | output | 1 | Transmit refill request |

## Verification
The threshold compare is driven with counts one below, equal to and one above the threshold, in both directions. This separates a strictly-greater compare from a greater-or-equal one. Thresholds above 12 are used to expose a missing clamp.

Each held cause is pulsed in both modes, so a cause accepted in the wrong mode is caught. Acknowledges are applied both alone and together with a cause, which checks hold-until-acknowledge and the rule that the cause wins. Frame-end transmit suppression is released once by a frame start and once by draining to empty.

A long stretch of seeded random counts, thresholds, pulses and mode changes is then compared cycle by cycle against a bench reference model.

// File: rtl/xfer_req_pkg.sv
package xfer_req_pkg;

  // Strobes decoded by the control half and consumed by the datapath half.
  typedef struct packed {
    logic setTo;    // latch receive timeout cause
    logic setEx;    // latch receive exception cause
    logic setEof;   // latch end-of-frame cause
    logic clrPend;  // host acknowledge of pending causes
    logic setDone;  // last frame character loaded into transmit FIFO
    logic clrDone;  // release transmit suppression
  } xferStrb_t;

endpackage

// File: rtl/xfer_req_ctrl.sv
module xfer_req_ctrl
  import xfer_req_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             syncMode,
  input  logic             rxTimeout,
  input  logic             rxExcept,
  input  logic             rxEof,
  input  logic             hostAck,
  input  logic             txWrite,
  input  logic             txLastChar,
  input  logic             txFrameStart,
  input  logic [CNT_W-1:0] txCount,
  output xferStrb_t        strb
);

  logic txEmpty;

  assign txEmpty = (txCount == '0);

  always_comb begin
    strb         = '0;
    // timeout and exception only matter on asynchronous links
    strb.setTo   = !syncMode && rxTimeout;
    strb.setEx   = !syncMode && rxExcept;
    // end of frame only matters on synchronous links
    strb.setEof  = syncMode && rxEof;
    strb.clrPend = hostAck;
    strb.setDone = syncMode && txWrite && txLastChar;
    strb.clrDone = txFrameStart || txEmpty;
  end

endmodule

// File: rtl/xfer_req_dp.sv
module xfer_req_dp
  import xfer_req_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int THR_W   = 4,
  parameter int THR_MAX = 12,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [THR_W-1:0] thrCfg,
  input  logic             syncMode,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] txCount,
  input  xferStrb_t        strb,
  output logic             rxReq,
  output logic             txReq
);

  localparam int CMP_W = CNT_W + 1;
  localparam logic [THR_W-1:0] THR_LIM  = THR_W'(THR_MAX);
  localparam logic [CMP_W-1:0] DEPTH_V  = CMP_W'(DEPTH);

  logic [THR_W-1:0] thrEff;
  logic [CMP_W-1:0] thrCmp;
  logic [CMP_W-1:0] rxCmp;
  logic [CMP_W-1:0] freeSpace;

  logic rxAbove, txRoom;
  logic pendTo, pendEx, pendEof, frameDone;

  // Clamp illegal thresholds to the largest legal one.
  assign thrEff    = (thrCfg > THR_LIM) ? THR_LIM : thrCfg;
  assign thrCmp    = CMP_W'(thrEff);
  assign rxCmp     = CMP_W'(rxCount);
  assign freeSpace = DEPTH_V - CMP_W'(txCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxAbove   <= 1'b0;
      txRoom    <= 1'b0;
      pendTo    <= 1'b0;
      pendEx    <= 1'b0;
      pendEof   <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      rxAbove <= (rxCmp > thrCmp);
      txRoom  <= (freeSpace > thrCmp);

      if (strb.setTo)        pendTo <= 1'b1;
      else if (strb.clrPend) pendTo <= 1'b0;

      if (strb.setEx)        pendEx <= 1'b1;
      else if (strb.clrPend) pendEx <= 1'b0;

      if (strb.setEof)       pendEof <= 1'b1;
      else if (strb.clrPend) pendEof <= 1'b0;

      if (strb.setDone)      frameDone <= 1'b1;
      else if (strb.clrDone) frameDone <= 1'b0;
    end
  end

  assign rxReq = rxAbove
               || (!syncMode && (pendTo || pendEx))
               || (syncMode && pendEof);
  assign txReq = txRoom && !(syncMode && frameDone);

  AST_RX_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    (rxCmp > thrCmp) |=> rxReq);                                        // R2

  AST_THR_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    ((thrCfg > THR_LIM) && (rxCmp > CMP_W'(THR_MAX))) |=> rxReq);       // R3

  AST_TX_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (CMP_W'(txCount) == DEPTH_V) |=> !txReq);                           // R4

  AST_TO_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    strb.setTo |=> (rxReq || syncMode));                                // R5

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrPend && !strb.setTo) |=> !pendTo);                         // R5

  AST_EOF_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    strb.setEof |=> (rxReq || !syncMode));                              // R6

  AST_DONE_MUTE: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDone |=> (!txReq || !syncMode));                            // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setEof && strb.clrPend) |=> pendEof);                         // R10

endmodule

// File: rtl/xfer_req_gen.sv
module xfer_req_gen
  import xfer_req_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int THR_W   = 4,
  parameter int THR_MAX = 12,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [THR_W-1:0] thrCfg,
  input  logic             syncMode,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] txCount,
  input  logic             rxTimeout,
  input  logic             rxExcept,
  input  logic             rxEof,
  input  logic             txWrite,
  input  logic             txLastChar,
  input  logic             txFrameStart,
  input  logic             hostAck,
  output logic             rxReq,
  output logic             txReq
);

  xferStrb_t strb;

  xfer_req_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .syncMode     (syncMode),
    .rxTimeout    (rxTimeout),
    .rxExcept     (rxExcept),
    .rxEof        (rxEof),
    .hostAck      (hostAck),
    .txWrite      (txWrite),
    .txLastChar   (txLastChar),
    .txFrameStart (txFrameStart),
    .txCount      (txCount),
    .strb         (strb)
  );

  xfer_req_dp #(
    .DEPTH   (DEPTH),
    .THR_W   (THR_W),
    .THR_MAX (THR_MAX),
    .CNT_W   (CNT_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .thrCfg   (thrCfg),
    .syncMode (syncMode),
    .rxCount  (rxCount),
    .txCount  (txCount),
    .strb     (strb),
    .rxReq    (rxReq),
    .txReq    (txReq)
  );

endmodule

// File: tb/sim_xfer_req_gen.sv
module sim_xfer_req_gen;

  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 4000;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] thrCfg = 4'd12;
  logic       syncMode = 1'b0;
  logic [4:0] rxCount = '0;
  logic [4:0] txCount = '0;
  logic       rxTimeout = 1'b0, rxExcept = 1'b0, rxEof = 1'b0;
  logic       txWrite = 1'b0, txLastChar = 1'b0, txFrameStart = 1'b0;
  logic       hostAck = 1'b0;
  logic       rxReq, txReq;

  int  nChk = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  // reference model state
  bit mAbove, mRoom, mTo, mEx, mEof, mDone;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_req_gen u0 (
    .clk(clk), .rstN(rstN), .thrCfg(thrCfg), .syncMode(syncMode),
    .rxCount(rxCount), .txCount(txCount), .rxTimeout(rxTimeout),
    .rxExcept(rxExcept), .rxEof(rxEof), .txWrite(txWrite),
    .txLastChar(txLastChar), .txFrameStart(txFrameStart),
    .hostAck(hostAck), .rxReq(rxReq), .txReq(txReq)
  );

  function automatic int effThr(input logic [3:0] c);
    return (c > 4'd12) ? 12 : int'(c);
  endfunction

  function automatic bit expRx();
    return mAbove || (!syncMode && (mTo || mEx)) || (syncMode && mEof);
  endfunction

  function automatic bit expTx();
    return mRoom && !(syncMode && mDone);
  endfunction

  task automatic modelEdge();
    if (!rstN) begin
      {mAbove, mRoom, mTo, mEx, mEof, mDone} = '0;
    end else begin
      mAbove = int'(rxCount) > effThr(thrCfg);
      mRoom  = (16 - int'(txCount)) > effThr(thrCfg);
      if (!syncMode && rxTimeout) mTo = 1; else if (hostAck) mTo = 0;
      if (!syncMode && rxExcept)  mEx = 1; else if (hostAck) mEx = 0;
      if (syncMode && rxEof)      mEof = 1; else if (hostAck) mEof = 0;
      if (syncMode && txWrite && txLastChar) mDone = 1;
      else if (txFrameStart || txCount == 0) mDone = 0;
    end
  endtask

  // advance one clock; outputs are sampled at the following falling edge
  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input bit act, input bit exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic clearPulses();
    rxTimeout = 0; rxExcept = 0; rxEof = 0;
    txWrite = 0; txLastChar = 0; txFrameStart = 0; hostAck = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual expired expected completion");
    finish();
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    tick(); tick();
    chk("R1", "rxReq in reset", rxReq, 1'b0);
    chk("R1", "txReq in reset", txReq, 1'b0);
    rstN = 1;
    tick();
    chk("R1", "rxReq after reset", rxReq, 1'b0);
    chk("R4", "txReq empty fifo thr12", txReq, 1'b1);

    // R2 receive threshold edge
    thrCfg = 4'd5; rxCount = 5'd5; tick();
    chk("R2", "rx equal to thr", rxReq, 1'b0);
    rxCount = 5'd6; tick();
    chk("R2", "rx above thr", rxReq, 1'b1);
    rxCount = 5'd0; tick();
    chk("R9", "rx drop after one clock", rxReq, 1'b0);

    // R3 clamp
    thrCfg = 4'd15; rxCount = 5'd12; tick();
    chk("R3", "clamped thr, rx 12", rxReq, 1'b0);
    rxCount = 5'd13; tick();
    chk("R3", "clamped thr, rx 13", rxReq, 1'b1);
    rxCount = 5'd0; tick();

    // R4 transmit free space
    thrCfg = 4'd4; txCount = 5'd12; tick();
    chk("R4", "free equal to thr", txReq, 1'b0);
    txCount = 5'd11; tick();
    chk("R4", "free above thr", txReq, 1'b1);
    thrCfg = 4'd0; txCount = 5'd16; tick();
    chk("R4", "full fifo", txReq, 1'b0);
    txCount = 5'd15; tick();
    chk("R9", "tx rises one clock after room", txReq, 1'b1);
    txCount = 5'd0;

    // R5 async held causes
    syncMode = 0; rxTimeout = 1; tick(); clearPulses();
    chk("R5", "timeout raises", rxReq, 1'b1);
    tick();
    chk("R5", "timeout held", rxReq, 1'b1);
    hostAck = 1; tick(); clearPulses();
    chk("R5", "timeout cleared by ack", rxReq, 1'b0);
    rxExcept = 1; tick(); clearPulses();
    chk("R5", "exception raises", rxReq, 1'b1);
    hostAck = 1; tick(); clearPulses();
    chk("R5", "exception cleared by ack", rxReq, 1'b0);

    // R7 eof ignored in async
    rxEof = 1; tick(); clearPulses();
    chk("R7", "eof in async", rxReq, 1'b0);

    // R6 sync causes
    syncMode = 1;
    rxTimeout = 1; tick(); clearPulses();
    chk("R6", "timeout in sync", rxReq, 1'b0);
    rxExcept = 1; tick(); clearPulses();
    chk("R6", "exception in sync", rxReq, 1'b0);
    rxEof = 1; tick(); clearPulses();
    chk("R6", "eof raises", rxReq, 1'b1);
    tick();
    chk("R6", "eof held", rxReq, 1'b1);
    hostAck = 1; tick(); clearPulses();
    chk("R6", "eof cleared by ack", rxReq, 1'b0);

    // R10 cause wins over ack
    rxEof = 1; hostAck = 1; tick(); clearPulses();
    chk("R10", "eof with ack", rxReq, 1'b1);
    hostAck = 1; tick(); clearPulses();
    chk("R10", "later ack clears", rxReq, 1'b0);

    // R8 frame-end suppression
    thrCfg = 4'd0; txCount = 5'd2; tick();
    chk("R8", "room before last char", txReq, 1'b1);
    txWrite = 1; txLastChar = 1; tick(); clearPulses();
    chk("R8", "suppressed after last char", txReq, 1'b0);
    tick();
    chk("R8", "suppression held", txReq, 1'b0);
    txFrameStart = 1; tick(); clearPulses();
    chk("R8", "released by frame start", txReq, 1'b1);
    txWrite = 1; txLastChar = 1; tick(); clearPulses();
    chk("R8", "suppressed again", txReq, 1'b0);
    txCount = 5'd0; tick();
    chk("R8", "released by empty fifo", txReq, 1'b1);
    syncMode = 0; txCount = 5'd2; txWrite = 1; txLastChar = 1; tick(); clearPulses();
    chk("R8", "last char ignored in async", txReq, 1'b1);

    // seeded random against the model
    for (int i = 0; i < N_RAND; i++) begin
      thrCfg       = 4'($urandom % 16);
      rxCount      = 5'($urandom % 17);
      txCount      = 5'($urandom % 17);
      rxTimeout    = ($urandom % 8) == 0;
      rxExcept     = ($urandom % 8) == 0;
      rxEof        = ($urandom % 6) == 0;
      hostAck      = ($urandom % 6) == 0;
      txWrite      = ($urandom % 3) == 0;
      txLastChar   = ($urandom % 4) == 0;
      txFrameStart = ($urandom % 20) == 0;
      if (($urandom % 50) == 0) syncMode = ~syncMode;
      tick();
      chk("R2", "random rxReq", rxReq, expRx());
      chk("R4", "random txReq", txReq, expTx());
    end

    finish();
  end

endmodule